// File: doc/BRIEF.md
# Command Mailbox Target Responder

This block is an AXI4-Lite slave that plays the target end of a command mailbox, so a host-side sequencer can be exercised against it. It holds seven parameter words, a request word, a block status word, a response status word and three response data words, all decoded from fixed byte offsets. A write to the request word starts a command. The block latches the request, counts a parameterised latency, then fills the response words according to the command and raises a ready flag.

The host polls the response status word for the ready flag, reads the payload, and clears the flag by writing it to 0. Only the interface-information command has a payload. That payload comes from a parameterised table of up to three (type, instance) entries plus an entry count. Every other command completes with an all-zero payload. A request written while a command is still counting is accepted on the bus but otherwise dropped, and it raises a sticky error bit. Writes are full-word; byte strobes and protection bits are not modelled.

Top module: `mbox_target`

## Requirements
- R1: After reset, every mapped register reads 0, including the ready flag (bit 0 of 0x45C) and the block status at 0x400.
- R2: Every write gets BRESP OKAY and every read gets RRESP OKAY. A read from an unmapped offset, such as 0x004, returns 0.
- R3: The seven parameter words at 0x420, 0x424, … 0x438 can be written and read back independently. Parameter n sits at 0x438 − 4·n.
- R4: A write to 0x43C, accepted while no command is pending, stores the request word (readable at 0x43C) and starts a command. Bit 0 of 0x400 reads 1 while that command is pending.
- R5: The clock edge that comes LATENCY cycles after the request write's handshake edge sets the ready flag. A read accepted on that edge still returns 0, and a read accepted one cycle later returns 1.
- R6: A request with command type 0x01 in bits [23:16] and opcode 0x0001 in bits [15:0] returns interface information. 0x45C bits [31:16] carry the interface count. The data word at 0x458 − 4·k holds entry k's type in [31:29] and its instance in [28:24] for k below the count, and reads 0 otherwise. With the default table (one entry, type 1, instance 0): 0x458 = 0x2000_0000, 0x454 = 0, 0x450 = 0, 0x45C = 0x0001_0001.
- R7: Any other command completes with the ready flag set, count 0 and all three data words 0.
- R8: Once set, the ready flag stays set until a write to 0x45C with bit 0 = 0. A write with bit 0 = 1 leaves it set. Clearing the flag does not change the count field.
- R9: If a clearing write to 0x45C lands on the same edge as a completion, the flag ends up set.
- R10: A request write while a command is pending leaves the stored request and the coming response unchanged, and sets bit 1 of 0x400. That bit stays set until a write to 0x400 with bit 1 = 1.
- R11: Writes to the response data words 0x450, 0x454 and 0x458 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| awAddr | input | 12 | Write byte offset |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| wData | input | 32 | Write data |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| bResp | output | 2 | Write response code (always OKAY) |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| arAddr | input | 12 | Read byte offset |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response code (always OKAY) |

## Verification
The command engine's completion and the host's flag-clearing write can land on the same edge. The bench provokes this by counting LATENCY cycles from the request handshake and timing a 0 write to the response status so that its handshake falls exactly on the completion edge. The outcome is judged by reading the flag back afterwards: it must be set, and a second clearing write must then clear it. A request arriving during the pending window is a second overlap. It is provoked with back-to-back request writes, and it is judged through the error bit, the unchanged request word and the payload of the first command.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int NUM_PARAM = 7;
  localparam int NUM_RESP  = 3;

  localparam logic [ADDR_W-1:0] OFF_STATUS   = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_PARAM_LO = 12'h420;
  localparam logic [ADDR_W-1:0] OFF_PARAM_HI = 12'h438;
  localparam logic [ADDR_W-1:0] OFF_REQ      = 12'h43C;
  localparam logic [ADDR_W-1:0] OFF_RESP_2   = 12'h450;
  localparam logic [ADDR_W-1:0] OFF_RESP_1   = 12'h454;
  localparam logic [ADDR_W-1:0] OFF_RESP_0   = 12'h458;
  localparam logic [ADDR_W-1:0] OFF_RSTAT    = 12'h45C;

  localparam logic [7:0]  CMDT_SYSINFO = 8'h01;
  localparam logic [15:0] OPC_IFINFO   = 16'h0001;

  typedef struct packed {
    logic       paramWe;
    logic [2:0] paramSel;
    logic       reqStart;
    logic       reqCollide;
    logic       errClr;
    logic       readyClr;
    logic       done;
    logic       busy;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  output logic              awReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              wValid,
  output logic              wReady,
  input  logic [1:0]        wLow,
  output logic              bValid,
  input  logic              bReady,
  output logic [1:0]        bResp,
  input  logic              arValid,
  output logic              arReady,
  output logic              rValid,
  input  logic              rReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  input  logic [DATA_W-1:0] rdWord,
  output mboxStrobe_t       strb
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic wrFire, arFire, busy, isReq;

  // A write needs address and data together and a free response slot.
  assign wrFire  = awValid && wValid && (!bValid || bReady);
  assign awReady = wrFire;
  assign wReady  = wrFire;
  assign arReady = !rValid || rReady;
  assign arFire  = arValid && arReady;
  assign bResp   = 2'b00;
  assign rResp   = 2'b00;

  assign busy  = (cnt != '0);
  assign isReq = wrFire && (awAddr == OFF_REQ);

  always_comb begin
    strb            = '0;
    strb.busy       = busy;
    strb.done       = (cnt == CNT_LAST);
    strb.paramWe    = wrFire && (awAddr >= OFF_PARAM_LO) && (awAddr <= OFF_PARAM_HI)
                      && (awAddr[1:0] == 2'b00);
    strb.paramSel   = 3'((OFF_PARAM_HI - awAddr) >> 2);
    strb.reqStart   = isReq && !busy;
    strb.reqCollide = isReq && busy;
    strb.errClr     = wrFire && (awAddr == OFF_STATUS) && wLow[1];
    strb.readyClr   = wrFire && (awAddr == OFF_RSTAT) && !wLow[0];
  end

  // Latency counter: loaded on an accepted request, done when it reaches 1.
  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strb.reqStart) cnt <= CNT_LOAD;
    else if (busy)          cnt <= cnt - CNT_LAST;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       bValid <= 1'b0;
    else if (wrFire) bValid <= 1'b1;
    else if (bReady) bValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
    end else if (arFire) begin
      rValid <= 1'b1;
      rData  <= rdWord;
    end else if (rReady) begin
      rValid <= 1'b0;
    end
  end

  p_busy_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqStart |=> (cnt == CNT_LOAD));
  p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid);
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid && $stable(rData));
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int                     IF_COUNT = 1,
  parameter logic [8*NUM_RESP-1:0]  IF_TABLE = 24'h000020
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strb,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdWord
);
  logic [NUM_PARAM-1:0][DATA_W-1:0] paramReg;
  logic [NUM_RESP-1:0][DATA_W-1:0]  respData, respNext;
  logic [DATA_W-1:0] reqReg;
  logic [15:0]       respCount;
  logic              ready, errSticky, isInfo, rdInParam;
  logic [2:0]        rdParamSel;

  assign isInfo = (reqReg[23:16] == CMDT_SYSINFO) && (reqReg[15:0] == OPC_IFINFO);

  for (genvar k = 0; k < NUM_RESP; k++) begin : g_resp
    assign respNext[k] = (isInfo && (k < IF_COUNT)) ? {IF_TABLE[8*k +: 8], 24'h0} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paramReg  <= '0;
      reqReg    <= '0;
      respData  <= '0;
      respCount <= '0;
    end else begin
      if (strb.paramWe)  paramReg[strb.paramSel] <= wData;
      if (strb.reqStart) reqReg <= wData;
      if (strb.done) begin
        respData  <= respNext;
        respCount <= isInfo ? 16'(IF_COUNT) : 16'h0;
      end
    end
  end

  // Completion wins over a clear in the same cycle; collision wins over a clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ready     <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      if (strb.done)          ready <= 1'b1;
      else if (strb.readyClr) ready <= 1'b0;
      if (strb.reqCollide)    errSticky <= 1'b1;
      else if (strb.errClr)   errSticky <= 1'b0;
    end
  end

  assign rdInParam  = (rdAddr >= OFF_PARAM_LO) && (rdAddr <= OFF_PARAM_HI) && (rdAddr[1:0] == 2'b00);
  assign rdParamSel = 3'((OFF_PARAM_HI - rdAddr) >> 2);

  always_comb begin
    rdWord = '0;
    if (rdInParam) rdWord = paramReg[rdParamSel];
    else begin
      case (rdAddr)
        OFF_STATUS: rdWord = {30'h0, errSticky, strb.busy};
        OFF_REQ:    rdWord = reqReg;
        OFF_RESP_2: rdWord = respData[2];
        OFF_RESP_1: rdWord = respData[1];
        OFF_RESP_0: rdWord = respData[0];
        OFF_RSTAT:  rdWord = {respCount, 15'h0, ready};
        default:    rdWord = '0;
      endcase
    end
  end

  p_done_sets_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> ready);
  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready && !strb.readyClr |=> ready);
  p_collide_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqCollide |=> errSticky && $stable(reqReg));
  p_resp_readonly_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.done |=> $stable(respData));
endmodule

// File: rtl/mbox_target.sv
module mbox_target
  import mbox_pkg::*;
#(
  parameter int                    LATENCY  = 8,
  parameter int                    IF_COUNT = 1,
  parameter logic [8*NUM_RESP-1:0] IF_TABLE = 24'h000020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  output logic              awReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              wValid,
  output logic              wReady,
  input  logic [DATA_W-1:0] wData,
  output logic              bValid,
  input  logic              bReady,
  output logic [1:0]        bResp,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ADDR_W-1:0] arAddr,
  output logic              rValid,
  input  logic              rReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp
);
  mboxStrobe_t       strb;
  logic [DATA_W-1:0] rdWord;

  mbox_ctrl #(.LATENCY(LATENCY)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wLow(wData[1:0]),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
    .rdWord(rdWord), .strb(strb)
  );

  mbox_dp #(.IF_COUNT(IF_COUNT), .IF_TABLE(IF_TABLE)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(wData),
    .rdAddr(arAddr), .rdWord(rdWord)
  );
endmodule

// File: tb/mbox_target_tb_top.sv
`timescale 1ns/1ps
module mbox_target_tb_top;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic awValid = 1'b0, wValid = 1'b0, arValid = 1'b0;
  logic bReady = 1'b1, rReady = 1'b1;
  logic [11:0] awAddr = '0, arAddr = '0;
  logic [31:0] wData = '0;
  logic awReady, wReady, bValid, arReady, rValid;
  logic [1:0]  bResp, rResp;
  logic [31:0] rData;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mbox_target #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; handshake on the next posedge; returns at the following negedge.
  task automatic axiWrite(input logic [11:0] a, input logic [31:0] d);
    awAddr = a; wData = d; awValid = 1'b1; wValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    awValid = 1'b0; wValid = 1'b0;
    check("R2 bresp", {29'h0, bValid, bResp}, 32'h4);
  endtask

  task automatic axiRead(input logic [11:0] a, output logic [31:0] d);
    arAddr = a; arValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arValid = 1'b0;
    check("R2 rresp", {29'h0, rValid, rResp}, 32'h4);
    d = rData;
  endtask

  task automatic testReset();
    logic [31:0] v;
    axiRead(12'h400, v); check("R1 status", v, 32'h0);
    axiRead(12'h43C, v); check("R1 request", v, 32'h0);
    axiRead(12'h45C, v); check("R1 resp status", v, 32'h0);
    axiRead(12'h458, v); check("R1 resp data0", v, 32'h0);
    axiRead(12'h004, v); check("R2 unmapped read", v, 32'h0);
  endtask

  task automatic testParams();
    logic [31:0] v;
    axiWrite(12'h420, 32'hA5A5_0006);
    axiWrite(12'h438, 32'h1234_0000);
    axiRead(12'h420, v); check("R3 param6", v, 32'hA5A5_0006);
    axiRead(12'h438, v); check("R3 param0", v, 32'h1234_0000);
    axiRead(12'h42C, v); check("R3 param3 untouched", v, 32'h0);
  endtask

  task automatic testInfo();
    logic [31:0] v;
    axiWrite(12'h43C, 32'h0001_0001);            // handshake at E0
    axiRead(12'h400, v); check("R4 busy bit", v, 32'h1);   // E1
    axiRead(12'h43C, v); check("R4 request stored", v, 32'h0001_0001); // E2
    repeat (LAT - 3) @(negedge clk);
    axiRead(12'h45C, v); check("R5 flag not yet at E_LAT", v, 32'h0); // E_LAT
    axiRead(12'h45C, v); check("R5 R6 flag and count", v, 32'h0001_0001);
    axiRead(12'h458, v); check("R6 data0", v, 32'h2000_0000);
    axiRead(12'h454, v); check("R6 data1", v, 32'h0);
    axiRead(12'h450, v); check("R6 data2", v, 32'h0);
    axiRead(12'h400, v); check("R4 busy cleared", v, 32'h0);
    axiWrite(12'h45C, 32'h0000_0001);
    axiRead(12'h45C, v); check("R8 write 1 keeps flag", v, 32'h0001_0001);
    axiWrite(12'h45C, 32'h0000_0000);
    axiRead(12'h45C, v); check("R8 clear keeps count", v, 32'h0001_0000);
  endtask

  task automatic testClearCollision();
    logic [31:0] v;
    axiWrite(12'h43C, 32'h0001_0001);            // E0
    repeat (LAT - 1) @(negedge clk);
    axiWrite(12'h45C, 32'h0);                    // lands on E_LAT
    axiRead(12'h45C, v); check("R9 set beats clear", v, 32'h0001_0001);
    axiWrite(12'h45C, 32'h0);
    axiRead(12'h45C, v); check("R9 later clear works", v, 32'h0001_0000);
  endtask

  task automatic testOther();
    logic [31:0] v;
    axiWrite(12'h43C, 32'h0002_0005);
    repeat (LAT + 1) @(negedge clk);
    axiRead(12'h45C, v); check("R7 other opcode status", v, 32'h0000_0001);
    axiRead(12'h458, v); check("R7 other opcode data0", v, 32'h0);
    axiWrite(12'h45C, 32'h0);
  endtask

  task automatic testCollide();
    logic [31:0] v;
    axiWrite(12'h43C, 32'h0001_0001);
    axiWrite(12'h43C, 32'h0002_0005);
    axiRead(12'h400, v); check("R10 error and busy", v, 32'h3);
    axiRead(12'h43C, v); check("R10 request kept", v, 32'h0001_0001);
    repeat (LAT + 1) @(negedge clk);
    axiRead(12'h458, v); check("R10 first command answered", v, 32'h2000_0000);
    axiRead(12'h400, v); check("R10 error sticky", v, 32'h2);
    axiWrite(12'h400, 32'h2);
    axiRead(12'h400, v); check("R10 error cleared", v, 32'h0);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    axiWrite(12'h458, 32'hFFFF_FFFF);
    axiWrite(12'h450, 32'h1234_5678);
    axiRead(12'h458, v); check("R11 data0 unchanged", v, 32'h2000_0000);
    axiRead(12'h450, v); check("R11 data2 unchanged", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testParams();
    testInfo();
    testClearCollision();
    testOther();
    testCollide();
    testReadOnly();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule